// File: doc/BRIEF.md
# Dual-Tone FSK Direct Digital Synthesizer

This block produces the digital carrier samples for a spread-FSK power-line modem. Two 16-bit step values set the two tones. The space tone carries data 0 and the mark tone carries data 1. Each step value is added into an 18-bit phase accumulator on every enabled tick. The tone frequency is therefore step × f_tick / 2^18. With a nominal tick rate of 3 MHz, that tick comes from a clock-enable strobe taken from a faster system clock.

A mode input selects between two output modes:
- **Transmit:** a single sine stream follows the current data bit.
- **Receive:** in-phase and quadrature samples for both tones run continuously, for a downstream mixer.

Both phases restart from zero when transmission begins. Software loads the step values through a small write port that has a one-bit register select.

Top module: `fsk_dds`

## Requirements
- R1: A write with `wr_en`=1 loads `wr_data` into the space step when `wr_sel`=0, or into the mark step when `wr_sel`=1. Both steps read zero after `rst` and after `soft_rst`. A `soft_rst` in the same cycle as a write wins over the write.
- R2: Each tone has its own 18-bit phase. On every cycle with `ce`=1, the phase adds its zero-extended step, modulo 2^18. With `ce`=0 the phase holds.
- R3: Both phases go to zero on `rst`, on `soft_rst`, and on the first cycle in which `tx_mode` is 1 after having been 0. This restart does not depend on `ce`.
- R4: Writing a step value leaves the phases untouched. The new value is first used by the update on the cycle after the write. An update in the same cycle as the write still uses the old value.
- R5: The amplitude of an 18-bit phase p is formed as follows:
  - Let q = p[17:16] and i = p[15:8].
  - Let k = i when q is even, and k = 255 − i when q is odd.
  - Then m = round(2047·sin(π(k+0.5)/512)).
  - The amplitude is m for q < 2 and −m otherwise. It is 12-bit two's complement and never −2048.
  - Sine uses p itself. Cosine uses p + 2^16 modulo 2^18.
- R6: With `tx_mode`=1, `tx_sample` carries the sine of the space phase when `tx_bit`=0 and of the mark phase when `tx_bit`=1. All four receive outputs are zero.
- R7: With `tx_mode`=0, `space_sin`/`space_cos` carry the sine and cosine of the space phase, and `mark_sin`/`mark_cos` those of the mark phase. `tx_sample` is zero.
- R8: Every output is a register. The value present after a clock edge is computed from the phases, `tx_mode` and `tx_bit` as they stood before that edge. All outputs are zero after a cycle with `rst`=1.
- R9: `rst` overrides everything. Next come `soft_rst` and the transmit restart, which override a phase update and a step write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Synchronous soft reset of steps and phases |
| ce | input | 1 | Synthesizer tick; gates phase updates |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| tx_bit | input | 1 | Data bit selecting the transmit tone |
| wr_en | input | 1 | Step register write strobe |
| wr_sel | input | 1 | 0 = space step, 1 = mark step |
| wr_data | input | 16 | Step value to write |
| tx_sample | output | 12 | Transmit sine sample |
| space_sin | output | 12 | Space tone sine (receive) |
| space_cos | output | 12 | Space tone cosine (receive) |
| mark_sin | output | 12 | Mark tone sine (receive) |
| mark_cos | output | 12 | Mark tone cosine (receive) |

## Verification
The assertions assume that every input is synchronous to `clk` and settled at the sampling edge. They also assume that `rst` is high from time zero until the first edges have passed, so that the restart and hold properties see a defined history of `tx_mode`.

The stimulus drives all inputs on the falling edge and holds `rst` from the start. It moves through several phases:
- steady and strobed `ce`;
- steps written in the middle of a run;
- mode changes with and without `ce`;
- a soft reset that coincides with a write and a transmit start;
- a full-scale step that wraps the phase.

The bench compares every output against a behavioural model on every clock.

// File: rtl/fskdds_pkg.sv
package fskdds_pkg;
  localparam real DDS_PI = 3.14159265358979323846;
  typedef enum logic {TONE_SPACE = 1'b0, TONE_MARK = 1'b1} tone_e;
endpackage

// File: rtl/fskdds_quarter_rom.sv
// Quarter-wave magnitude table, sampled at half-step offsets so that the
// table is symmetric about the quarter point.
module fskdds_quarter_rom #(
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  mag
);
  import fskdds_pkg::*;

  localparam int  DEPTH = 1 << ADDR_W;
  localparam real PEAK  = real'((1 << MAG_W) - 1);

  logic [MAG_W-1:0] rom_q [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      rom_q[k] = MAG_W'($rtoi(PEAK * $sin(DDS_PI * (real'(k) + 0.5) / real'(2 * DEPTH)) + 0.5));
    end
  end

  assign mag = rom_q[addr];
endmodule

// File: rtl/fskdds_phase_amp.sv
// Phase-to-amplitude: quadrant folding around the quarter-wave table.
module fskdds_phase_amp #(
  parameter int LUT_AW = 8,
  parameter int OUT_W  = 12,
  parameter bit COS    = 1'b0
) (
  input  logic [LUT_AW+1:0]        phase_top,
  output logic signed [OUT_W-1:0]  amp
);
  localparam int PT_W = LUT_AW + 2;
  localparam logic [PT_W-1:0] QTR = COS ? (PT_W'(1) << LUT_AW) : '0;

  logic [PT_W-1:0]   ph;
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [LUT_AW-1:0] addr;
  logic [OUT_W-2:0]  mag;
  logic [OUT_W-1:0]  mag_ext;

  assign ph   = phase_top + QTR;
  assign quad = ph[PT_W-1 -: 2];
  assign idx  = ph[LUT_AW-1:0];
  assign addr = quad[0] ? ~idx : idx;

  fskdds_quarter_rom #(
    .ADDR_W(LUT_AW),
    .MAG_W (OUT_W - 1)
  ) u_rom (
    .addr(addr),
    .mag (mag)
  );

  assign mag_ext = {1'b0, mag};

  always_comb begin
    if (quad[1]) amp = -signed'(mag_ext);
    else         amp =  signed'(mag_ext);
  end
endmodule

// File: rtl/fskdds_tone_acc.sv
// One tone: step register and phase accumulator.
module fskdds_tone_acc #(
  parameter int STEP_W = 16,
  parameter int ACC_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              restart,
  input  logic              ce,
  input  logic              step_we,
  input  logic [STEP_W-1:0] step_din,
  output logic [ACC_W-1:0]  phase
);
  logic [STEP_W-1:0] step_q;
  logic [ACC_W-1:0]  acc_q;

  always_ff @(posedge clk) begin
    if (rst || soft_rst)  step_q <= '0;
    else if (step_we)     step_q <= step_din;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst || restart) acc_q <= '0;
    else if (ce)                    acc_q <= acc_q + ACC_W'(step_q);
  end

  assign phase = acc_q;
endmodule

// File: rtl/fsk_dds.sv
module fsk_dds #(
  parameter int STEP_W = 16,
  parameter int ACC_W  = 18,
  parameter int LUT_AW = 8,
  parameter int OUT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    soft_rst,
  input  logic                    ce,
  input  logic                    tx_mode,
  input  logic                    tx_bit,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [STEP_W-1:0]       wr_data,
  output logic signed [OUT_W-1:0] tx_sample,
  output logic signed [OUT_W-1:0] space_sin,
  output logic signed [OUT_W-1:0] space_cos,
  output logic signed [OUT_W-1:0] mark_sin,
  output logic signed [OUT_W-1:0] mark_cos
);
  import fskdds_pkg::*;

  localparam int NUM_TONES = 2;
  localparam int NUM_CH    = 2 * NUM_TONES;
  localparam int PT_W      = LUT_AW + 2;

  logic                    mode_q;
  logic                    restart;
  logic [ACC_W-1:0]        tone_phase [NUM_TONES];
  logic signed [OUT_W-1:0] ch_amp     [NUM_CH];
  logic [ACC_W-1:0]        phase_space;
  logic [ACC_W-1:0]        phase_mark;
  logic signed [OUT_W-1:0] tx_pick;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= tx_mode;
  end

  assign restart = tx_mode & ~mode_q;

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
    fskdds_tone_acc #(
      .STEP_W(STEP_W),
      .ACC_W (ACC_W)
    ) u_acc (
      .clk     (clk),
      .rst     (rst),
      .soft_rst(soft_rst),
      .restart (restart),
      .ce      (ce),
      .step_we (wr_en && (wr_sel == t[0])),
      .step_din(wr_data),
      .phase   (tone_phase[t])
    );
  end

  // channel c: tone c/2, sine when c is even, cosine when odd
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    fskdds_phase_amp #(
      .LUT_AW(LUT_AW),
      .OUT_W (OUT_W),
      .COS   (c[0])
    ) u_amp (
      .phase_top(tone_phase[c/2][ACC_W-1 -: PT_W]),
      .amp      (ch_amp[c])
    );
  end

  assign phase_space = tone_phase[TONE_SPACE];
  assign phase_mark  = tone_phase[TONE_MARK];
  assign tx_pick     = tx_bit ? ch_amp[2] : ch_amp[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sample <= '0;
      space_sin <= '0;
      space_cos <= '0;
      mark_sin  <= '0;
      mark_cos  <= '0;
    end else if (tx_mode) begin
      tx_sample <= tx_pick;
      space_sin <= '0;
      space_cos <= '0;
      mark_sin  <= '0;
      mark_cos  <= '0;
    end else begin
      tx_sample <= '0;
      space_sin <= ch_amp[0];
      space_cos <= ch_amp[1];
      mark_sin  <= ch_amp[2];
      mark_cos  <= ch_amp[3];
    end
  end
endmodule

// File: rtl/fskdds_checker.sv
module fskdds_checker #(
  parameter int ACC_W = 18,
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    soft_rst,
  input logic                    ce,
  input logic                    tx_mode,
  input logic [ACC_W-1:0]        phase_space,
  input logic [ACC_W-1:0]        phase_mark,
  input logic signed [OUT_W-1:0] tx_sample,
  input logic signed [OUT_W-1:0] space_sin,
  input logic signed [OUT_W-1:0] space_cos,
  input logic signed [OUT_W-1:0] mark_sin,
  input logic signed [OUT_W-1:0] mark_cos
);
  localparam logic signed [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

  AST_RX_SILENT_IN_TX: assert property (@(posedge clk) disable iff (rst)
    tx_mode |=> (space_sin == 0 && space_cos == 0 && mark_sin == 0 && mark_cos == 0)); // R6

  AST_TX_SILENT_IN_RX: assert property (@(posedge clk) disable iff (rst)
    !tx_mode |=> (tx_sample == 0)); // R7

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_mode) |=> (phase_space == 0 && phase_mark == 0)); // R3

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (phase_space == 0 && phase_mark == 0)); // R3

  AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ce && !soft_rst && !$rose(tx_mode)) |=> ($stable(phase_space) && $stable(phase_mark))); // R2

  AST_NO_NEG_FULL: assert property (@(posedge clk) disable iff (rst)
    (tx_sample != NEG_FULL && space_sin != NEG_FULL && space_cos != NEG_FULL &&
     mark_sin != NEG_FULL && mark_cos != NEG_FULL)); // R5
endmodule

bind fsk_dds fskdds_checker #(
  .ACC_W(ACC_W),
  .OUT_W(OUT_W)
) u_fskdds_chk (
  .clk        (clk),
  .rst        (rst),
  .soft_rst   (soft_rst),
  .ce         (ce),
  .tx_mode    (tx_mode),
  .phase_space(phase_space),
  .phase_mark (phase_mark),
  .tx_sample  (tx_sample),
  .space_sin  (space_sin),
  .space_cos  (space_cos),
  .mark_sin   (mark_sin),
  .mark_cos   (mark_cos)
);

// File: tb/fsk_dds_bench.sv
`timescale 1ns/1ps
module fsk_dds_bench;
  localparam int  ACC_MASK = (1 << 18) - 1;
  localparam int  QUARTER  = 1 << 16;
  localparam real BPI      = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        ce = 1'b0;
  logic        tx_mode = 1'b0;
  logic        tx_bit = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic signed [11:0] tx_sample, space_sin, space_cos, mark_sin, mark_cos;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R8";
  bit    done = 1'b0;

  // reference state
  int m_step [2];
  int m_acc  [2];
  bit m_modeq = 1'b0;
  int m_tx = 0, m_ss = 0, m_sc = 0, m_ms = 0, m_mc = 0;

  fsk_dds u_fsk_dds (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .ce(ce), .tx_mode(tx_mode),
    .tx_bit(tx_bit), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tx_sample(tx_sample), .space_sin(space_sin), .space_cos(space_cos),
    .mark_sin(mark_sin), .mark_cos(mark_cos)
  );

  always #2.5 clk = ~clk;

  // amplitude rule of R5
  function automatic int ref_amp(int p);
    int q, i, k, m;
    q = (p >> 16) & 3;
    i = (p >> 8) & 255;
    k = (q % 2 == 1) ? 255 - i : i;
    m = $rtoi(2047.0 * $sin(BPI * (real'(k) + 0.5) / 512.0) + 0.5);
    return (q >= 2) ? -m : m;
  endfunction

  initial begin
    m_step[0] = 0; m_step[1] = 0; m_acc[0] = 0; m_acc[1] = 0;
  end

  always @(posedge clk) begin
    bit start;
    if (rst) begin
      m_tx = 0; m_ss = 0; m_sc = 0; m_ms = 0; m_mc = 0;
      m_acc[0] = 0; m_acc[1] = 0; m_step[0] = 0; m_step[1] = 0; m_modeq = 1'b0;
    end else begin
      if (tx_mode) begin
        m_tx = ref_amp(tx_bit ? m_acc[1] : m_acc[0]);
        m_ss = 0; m_sc = 0; m_ms = 0; m_mc = 0;
      end else begin
        m_tx = 0;
        m_ss = ref_amp(m_acc[0]);
        m_sc = ref_amp((m_acc[0] + QUARTER) & ACC_MASK);
        m_ms = ref_amp(m_acc[1]);
        m_mc = ref_amp((m_acc[1] + QUARTER) & ACC_MASK);
      end
      start = tx_mode && !m_modeq;
      m_modeq = tx_mode;
      for (int t = 0; t < 2; t++) begin
        if (soft_rst || start) m_acc[t] = 0;
        else if (ce)           m_acc[t] = (m_acc[t] + m_step[t]) & ACC_MASK;
      end
      if (soft_rst)   begin m_step[0] = 0; m_step[1] = 0; end
      else if (wr_en) m_step[wr_sel] = int'(wr_data);
    end
  end

  task automatic chk(string name, logic signed [11:0] act, int exp);
    n_chk++;
    if ($isunknown(act) || int'(act) != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("tx_sample", tx_sample, m_tx);
      chk("space_sin", space_sin, m_ss);
      chk("space_cos", space_cos, m_sc);
      chk("mark_sin",  mark_sin,  m_ms);
      chk("mark_cos",  mark_cos,  m_mc);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_step(bit sel, int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(val);
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit [12:0] pat = 13'b1011001110001;
    cyc(5);                               // R8: reset state observed
    rst = 1'b0;
    tag = "R1";
    write_step(1'b0, 1000);
    write_step(1'b1, 2400);
    tag = "R5"; ce = 1'b1; cyc(300);     // R5, R7 continuous receive
    tag = "R2";
    for (int i = 0; i < 240; i++) begin ce = (i % 3 == 0); cyc(1); end
    ce = 1'b0; cyc(20);                   // R2 hold
    tag = "R4";
    ce = 1'b1; write_step(1'b0, 7777); cyc(40);
    write_step(1'b1, 123); cyc(40);
    tag = "R3";
    ce = 1'b0; tx_mode = 1'b1; cyc(5);   // restart without ce
    tag = "R6"; ce = 1'b1;
    for (int i = 0; i < 400; i++) begin tx_bit = pat[i % 13]; cyc(1); end
    tag = "R7"; tx_mode = 1'b0; cyc(60);
    tag = "R3"; tx_mode = 1'b1; cyc(60); // restart with ce
    tag = "R9";
    soft_rst = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'd5000; cyc(1);
    soft_rst = 1'b0; wr_en = 1'b0; cyc(30);
    tag = "R1"; write_step(1'b1, 5000); write_step(1'b0, 300);
    tx_mode = 1'b0; cyc(100);
    tag = "R2"; write_step(1'b0, 65535); write_step(1'b1, 40000); cyc(300);
    tag = "R9"; tx_mode = 1'b1; soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
    for (int i = 0; i < 100; i++) begin tx_bit = pat[(i * 5) % 13]; cyc(1); end
    tag = "R8"; rst = 1'b1; wr_en = 1'b1; cyc(2);
    rst = 1'b0; wr_en = 1'b0; tx_mode = 1'b0; cyc(50);
    finish_run();
  end
endmodule